// File: doc/BRIEF.md
# Bus-Cycle Clock Switcher

This block picks which of two unrelated clocks drives a processor. Outside bus cycles, the processor runs from a fast accelerator clock. When the processor drops its active-low address strobe for an access outside the alternate RAM region, the block hands the processor back to the slower host-system clock, so the access meets host bus timing. When the strobe is released, the block returns the processor to the fast clock.

Each source clock has its own enable flip-flop. An enable changes only on the falling edge of its own clock. It is set only after a synchronizer in that clock's domain has seen the other enable low. Because of this, the output can never carry a runt pulse or a shortened phase. A handover therefore holds the output low for one stretched period.

After reset the block passes only the system clock. Acceleration stays locked out until software writes to a designated arming address. This keeps the stretched handover period away from the processor while the system clock may still run at its lowest rate.

Top module: `busclk_switch`

## Requirements
- R1: After reset is released and before arming, cpu_clk_o follows sys_clk_i whatever the strobe does, and both fast_sel_o and accel_on_o read 0.
- R2: accel_on_o goes to 1 after a sys_clk_i rising edge that samples as_ni=0, wr_ni=0 and arm_hit_i=1. It then stays at 1 until reset. A read (wr_ni=1) to the arming address does not arm the block, and neither does a write with arm_hit_i=0. The fast clock is never enabled while accel_on_o is 0.
- R3: When armed with as_ni=1, the handover completes within SYNC_STAGES+2 periods of each clock. After it, fast_sel_o=1 and cpu_clk_o follows fast_clk_i.
- R4: When armed with as_ni=0 and alt_hit_i=0, the handover completes within the same bound. After it, fast_sel_o=0 and cpu_clk_o follows sys_clk_i.
- R5: When armed with as_ni=0 and alt_hit_i=1, no switch is requested: fast_sel_o stays 1 and cpu_clk_o keeps following fast_clk_i.
- R6: The two source enables are never 1 together. Every high and low phase of cpu_clk_o lasts at least half a fast_clk_i period.
- R7: alt_access_o is 1 exactly when as_ni=0 and alt_hit_i=1, armed or not.
- R8: Asserting rst_ni low at any time forces cpu_clk_o low and clears fast_sel_o and accel_on_o. After release, the block is back in the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk_i | input | 1 | Fast accelerator clock |
| sys_clk_i | input | 1 | Host-system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_ni | input | 1 | Processor address strobe, active low |
| wr_ni | input | 1 | Processor write strobe, active low |
| arm_hit_i | input | 1 | Current address equals the arming address |
| alt_hit_i | input | 1 | Current address lies in the alternate RAM region |
| cpu_clk_o | output | 1 | Clock delivered to the processor |
| accel_on_o | output | 1 | Acceleration armed |
| fast_sel_o | output | 1 | Fast clock currently gated to the output |
| alt_access_o | output | 1 | Current strobe targets alternate RAM |

## Verification
The mutual-exclusion and lock-out assertions assume that as_ni, arm_hit_i and alt_hit_i stay stable for several periods of the slower clock. They also assume that no input changes on an edge of either clock. A request that toggles again before the previous handover has settled could let both domains see stale enables. The stimulus changes inputs only at instants offset from every clock edge and holds each bus state for sixty fast periods. It runs both a 1:3 and a 1:6 clock ratio, so every handover settles before the next one begins.

// File: rtl/busclk_pkg.sv
`timescale 1ns/1ps
package busclk_pkg;
  typedef enum logic {
    SRC_SYS  = 1'b0,
    SRC_FAST = 1'b1
  } clk_src_e;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/cs_sync.sv
`timescale 1ns/1ps
module cs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cs_arm_ctrl.sv
`timescale 1ns/1ps
module cs_arm_ctrl (
  input  logic sys_clk_i,
  input  logic rst_ni,
  input  logic as_ni,
  input  logic wr_ni,
  input  logic arm_hit_i,
  output logic armed_o
);
  logic arm_wr;
  logic armed_q;

  assign arm_wr = ~as_ni & ~wr_ni & arm_hit_i;

  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b0;
    else if (arm_wr) armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  AST_ARM_STICKY: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q);  // R2
  AST_ARM_ON_WRITE: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (!as_ni && !wr_ni && arm_hit_i) |=> armed_o);  // R2
endmodule

// File: rtl/cs_gate_stage.sv
`timescale 1ns/1ps
module cs_gate_stage #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic peer_en_i,
  output logic en_o
);
  logic want_s;
  logic peer_s;
  logic en_q;

  cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_want_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (want_i),
    .q_o   (want_s)
  );

  // peer enable seen in this domain; resets to "low" so a lone source can start
  cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_peer_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (peer_en_i),
    .q_o   (peer_s)
  );

  // falling-edge update: gate opens/closes only while own clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= want_s & ~peer_s;
  end

  assign en_o = en_q;
endmodule

// File: rtl/busclk_switch.sv
`timescale 1ns/1ps
module busclk_switch #(
  parameter int unsigned SYNC_STAGES = busclk_pkg::DEF_SYNC_STAGES
) (
  input  logic fast_clk_i,
  input  logic sys_clk_i,
  input  logic rst_ni,
  input  logic as_ni,
  input  logic wr_ni,
  input  logic arm_hit_i,
  input  logic alt_hit_i,
  output logic cpu_clk_o,
  output logic accel_on_o,
  output logic fast_sel_o,
  output logic alt_access_o
);
  import busclk_pkg::*;

  localparam int unsigned NSRC = NUM_SRC;

  logic            armed;
  logic            want_sys;
  logic [NSRC-1:0] src_clk;
  logic [NSRC-1:0] src_want;
  logic [NSRC-1:0] src_en;
  clk_src_e        cur_src;

  cs_arm_ctrl u_arm (
    .sys_clk_i(sys_clk_i),
    .rst_ni   (rst_ni),
    .as_ni    (as_ni),
    .wr_ni    (wr_ni),
    .arm_hit_i(arm_hit_i),
    .armed_o  (armed)
  );

  // system clock wanted when unarmed or for a strobe outside alt RAM
  assign want_sys = ~armed | (~as_ni & ~alt_hit_i);

  assign src_clk[SRC_SYS]   = sys_clk_i;
  assign src_clk[SRC_FAST]  = fast_clk_i;
  assign src_want[SRC_SYS]  = want_sys;
  assign src_want[SRC_FAST] = ~want_sys;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    cs_gate_stage #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_i    (src_clk[g]),
      .rst_ni   (rst_ni),
      .want_i   (src_want[g]),
      .peer_en_i(src_en[NSRC-1-g]),
      .en_o     (src_en[g])
    );
  end

  assign cur_src      = src_en[SRC_FAST] ? SRC_FAST : SRC_SYS;
  assign cpu_clk_o    = |(src_clk & src_en);
  assign fast_sel_o   = (cur_src == SRC_FAST);
  assign accel_on_o   = armed;
  assign alt_access_o = ~as_ni & alt_hit_i;

  AST_EN_EXCL_FAST: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    !(src_en[SRC_FAST] && src_en[SRC_SYS]));  // R6
  AST_EN_EXCL_SYS: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    !(src_en[SRC_FAST] && src_en[SRC_SYS]));  // R6
  AST_FAST_LOCKED: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    !armed |-> !src_en[SRC_FAST]);  // R2
endmodule

// File: tb/tb_busclk_switch.sv
`timescale 1ns/1ps
module tb_busclk_switch;
  localparam int SRC_SYS = 0, SRC_FAST = 1, SRC_LOW = 2;
  localparam int SETTLE = 60;

  typedef struct packed {
    logic       sel;
    logic       acc;
    logic       alt;
    logic [1:0] src;
  } exp_t;

  logic fast_clk = 1'b0, sys_clk = 1'b0, rst_n = 1'b0;
  logic as_n = 1'b1, wr_n = 1'b1, arm_hit = 1'b0, alt_hit = 1'b0;
  logic cpu_clk, accel_on, fast_sel, alt_access;
  int   sys_half = 12;
  int   checks = 0, failures = 0, phase_bad = 0;
  bit   done = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  event  chk_ev;

  busclk_switch dut (
    .fast_clk_i  (fast_clk),
    .sys_clk_i   (sys_clk),
    .rst_ni      (rst_n),
    .as_ni       (as_n),
    .wr_ni       (wr_n),
    .arm_hit_i   (arm_hit),
    .alt_hit_i   (alt_hit),
    .cpu_clk_o   (cpu_clk),
    .accel_on_o  (accel_on),
    .fast_sel_o  (fast_sel),
    .alt_access_o(alt_access)
  );

  initial forever #4 fast_clk = ~fast_clk;  // 125 MHz
  initial begin
    #1;
    forever #(sys_half) sys_clk = ~sys_clk;
  end

  // phase monitor (R6): no phase under half a fast period
  realtime last_t = 0.0;
  bit      have_last = 0;
  always @(cpu_clk) begin
    if (!rst_n) have_last = 0;
    else begin
      if (have_last && ($realtime - last_t) < 3.999) begin
        phase_bad++;
        $display("FAIL R6: phase of %0.3f ns at %0t, expected >= 4.000 ns",
                 $realtime - last_t, $time);
      end
      last_t    = $realtime;
      have_last = 1;
    end
  end

  // scoreboard monitor
  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      int    miss;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      miss = 0;
      if (fast_sel !== e.sel || accel_on !== e.acc || alt_access !== e.alt) miss++;
      for (int k = 0; k < 4; k++) begin
        logic ref_v;
        ref_v = (e.src == SRC_FAST) ? fast_clk : (e.src == SRC_SYS) ? sys_clk : 1'b0;
        if (cpu_clk !== ref_v) miss++;
        if (k < 3) #4;
      end
      checks++;
      if (miss != 0) begin
        failures++;
        $display("FAIL %s: sel/acc/alt=%b%b%b expected %b%b%b, clock mismatches=%0d expected 0 (src %0d)",
                 t, fast_sel, accel_on, alt_access, e.sel, e.acc, e.alt, miss, e.src);
      end
    end
  end

  task automatic align();
    @(negedge fast_clk);
    #2;
  endtask

  task automatic wait_fast(int n);
    repeat (n) @(posedge fast_clk);
  endtask

  task automatic set_bus(logic a, logic w, logic h, logic l);
    align();
    as_n = a; wr_n = w; arm_hit = h; alt_hit = l;
  endtask

  task automatic expect_state(string tag, logic sel, logic acc, logic alt, int src);
    exp_t e;
    align();
    e.sel = sel; e.acc = acc; e.alt = alt; e.src = 2'(src);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> chk_ev;
    #20;
  endtask

  task automatic step(logic a, logic w, logic h, logic l);
    set_bus(a, w, h, l);
    wait_fast(SETTLE);
  endtask

  task automatic do_arm();
    step(1'b0, 1'b0, 1'b1, 1'b0);
    expect_state("R2 arm write", 1'b0, 1'b1, 1'b0, SRC_SYS);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    expect_state("R3 fast after arm", 1'b1, 1'b1, 1'b0, SRC_FAST);
  endtask

  initial begin
    wait_fast(5);
    expect_state("R8 in reset", 1'b0, 1'b0, 1'b0, SRC_LOW);
    align(); rst_n = 1'b1;
    wait_fast(SETTLE);
    expect_state("R1 after reset", 1'b0, 1'b0, 1'b0, SRC_SYS);

    step(1'b0, 1'b1, 1'b1, 1'b0);
    expect_state("R2 read of arm addr", 1'b0, 1'b0, 1'b0, SRC_SYS);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    expect_state("R2 write elsewhere", 1'b0, 1'b0, 1'b0, SRC_SYS);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    expect_state("R7 alt strobe unarmed", 1'b0, 1'b0, 1'b1, SRC_SYS);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    expect_state("R1 idle unarmed", 1'b0, 1'b0, 1'b0, SRC_SYS);

    do_arm();
    for (int i = 0; i < 3; i++) begin
      step(1'b0, (i == 1) ? 1'b0 : 1'b1, 1'b0, 1'b0);
      expect_state("R4 host strobe", 1'b0, 1'b1, 1'b0, SRC_SYS);
      step(1'b1, 1'b1, 1'b0, 1'b0);
      expect_state("R3 strobe released", 1'b1, 1'b1, 1'b0, SRC_FAST);
      step(1'b0, 1'b1, 1'b0, 1'b1);
      expect_state("R5 alt strobe fast", 1'b1, 1'b1, 1'b1, SRC_FAST);
      step(1'b1, 1'b1, 1'b0, 1'b0);
      expect_state("R3 after alt", 1'b1, 1'b1, 1'b0, SRC_FAST);
    end

    align(); rst_n = 1'b0;
    wait_fast(3);
    expect_state("R8 reset while fast", 1'b0, 1'b0, 1'b0, SRC_LOW);
    sys_half = 24;
    align(); rst_n = 1'b1;
    wait_fast(SETTLE);
    expect_state("R8 back to slow", 1'b0, 1'b0, 1'b0, SRC_SYS);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    expect_state("R1 slow ratio strobe", 1'b0, 1'b0, 1'b0, SRC_SYS);
    step(1'b1, 1'b1, 1'b0, 1'b0);

    do_arm();
    step(1'b0, 1'b1, 1'b0, 1'b0);
    expect_state("R4 slow ratio strobe", 1'b0, 1'b1, 1'b0, SRC_SYS);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    expect_state("R3 slow ratio release", 1'b1, 1'b1, 1'b0, SRC_FAST);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    expect_state("R5 slow ratio alt", 1'b1, 1'b1, 1'b1, SRC_FAST);

    checks++;
    if (phase_bad != 0) begin
      failures++;
      $display("FAIL R6: %0d short phases, expected 0", phase_bad);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule